// File: doc/BRIEF.md
# Configurable Alert Output Controller

This block drives the enable of an active-low, open-drain alert pin for a measurement device. The configuration word picks one of two behaviours. In data-ready mode the pin is pulled low once a fresh result has been loaded, and it is let go when a bus master reads the result. In threshold mode the pin is pulled low for as long as the signed result is greater than a coarse threshold held in the upper bits of the same configuration word.

The threshold field is narrower than the result. It sits in the top bits of the result, and the lower bits are taken as zero, so the comparison has a resolution of 512 counts at the default widths. A mode change drops any pending data-ready indication. While the device is shut down, the pin stays released.

Top module: `alert_ctrl`

## Requirements
- R1: After reset `alert_oe_o` is 0 (pin released), and with a configuration word of zero the block is in data-ready mode.
- R2: In data-ready mode (cfg bit 8 = 0) a `new_data_i` pulse makes `alert_oe_o` 1 from the clock edge that samples it. It stays 1 until a read releases it.
- R3: In data-ready mode a `rd_strobe_i` pulse with no `new_data_i` in the same cycle makes `alert_oe_o` 0 from the clock edge that samples it.
- R4: When `new_data_i` and `rd_strobe_i` are both 1 in the same cycle, new data wins and `alert_oe_o` is 1 after that edge.
- R5: In threshold mode (cfg bit 8 = 1), after each clock edge `alert_oe_o` equals 1 exactly when the result sampled at that edge, read as a 16-bit two's-complement number, is greater than {cfg[15:9], 9'b0} read the same way. Otherwise it is 0.
- R6: The threshold comparison is signed and strict. A result equal to the threshold does not assert the pin. Negative thresholds (cfg bit 15 = 1) compare correctly with negative results.
- R7: Any clock edge at which cfg bit 8 differs from its value at the previous edge clears the pending data-ready indication. A return to data-ready mode therefore shows the pin released.
- R8: While cfg bit 4 = 1 (shutdown), `alert_oe_o` is 0 in that same cycle, in both modes. Any pending data-ready indication is cleared.
- R9: In threshold mode, `new_data_i` and `rd_strobe_i` have no effect on the pin, either at that time or after a later return to data-ready mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| new_data_i | input | 1 | One-cycle pulse: a new result was loaded |
| rd_strobe_i | input | 1 | One-cycle pulse: the result was read over the bus |
| result_i | input | 16 | Current output register contents, two's complement |
| cfg_i | input | 16 | Configuration word: bit 4 shutdown, bit 8 mode, bits 15:9 threshold |
| alert_oe_o | output | 1 | 1 = pull the alert pin low; 0 = high impedance |

## Verification
Three cases are hard to reach from the ports. The first is a new-data pulse and a read strobe that land on the same edge. The second is a data-ready indication left pending when the mode or the shutdown bit changes underneath it. The third is a new-data pulse taken while in threshold mode, which should leave no trace. The stimulus sets a pending flag and then, on the next edge, either pulses both strobes together or flips the mode or shutdown bit. It then returns to data-ready mode with no further pulses, so that any flag that wrongly survived shows up on the pin. Threshold cases sweep results just above, equal to and below both positive and negative thresholds.

// File: rtl/alert_pkg.sv
package alert_pkg;
   typedef enum logic {
      ALERT_READY = 1'b0,
      ALERT_LEVEL = 1'b1
   } alert_mode_e;

   localparam int unsigned DEF_DATA_W   = 16;
   localparam int unsigned DEF_THR_W    = 7;
   localparam int unsigned DEF_MODE_BIT = 8;
   localparam int unsigned DEF_SHDN_BIT = 4;
endpackage

// File: rtl/alert_ready_flag.sv
module alert_ready_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic rel_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (clr_i)
         flag_q <= 1'b0;
      else if (set_i)
         flag_q <= 1'b1;
      else if (rel_i)
         flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // R2: a new result sets the flag
   p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i && !clr_i |=> flag_o);
   // R3: a lone read releases the flag
   p_rel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rel_i && !set_i && !clr_i |=> !flag_o);
   // R4: new data beats a read in the same cycle
   p_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rel_i && set_i && !clr_i |=> flag_o);
   // R7: a clear request always empties the flag
   p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !flag_o);
   // R2: with no stimulus the flag holds
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !set_i && !rel_i && !clr_i |=> $stable(flag_o));
endmodule

// File: rtl/alert_level_cmp.sv
module alert_level_cmp #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned THR_W   = 7,
   parameter bit          REG_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] result_i,
   input  logic [THR_W-1:0]  thr_i,
   output logic              above_o
);
   localparam int unsigned PAD_W = DATA_W - THR_W;

   if (THR_W == 0 || THR_W > DATA_W) begin : g_bad_width
      $error("alert_level_cmp: THR_W must be 1..DATA_W");
   end

   logic signed [DATA_W-1:0] thr_full;
   logic                     above_now;

   always_comb begin
      thr_full  = $signed({thr_i, {PAD_W{1'b0}}});
      above_now = $signed(result_i) > thr_full;
   end

   if (REG_CMP) begin : g_reg
      logic above_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            above_q <= 1'b0;
         else
            above_q <= above_now;
      end
      assign above_o = above_q;

      // R6: a result equal to the threshold never raises the compare
      p_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (result_i == DATA_W'(thr_full)) |=> !above_o);
   end else begin : g_comb
      assign above_o = above_now;
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
   end
endmodule

// File: rtl/alert_ctrl.sv
module alert_ctrl
   import alert_pkg::*;
#(
   parameter int unsigned DATA_W   = DEF_DATA_W,
   parameter int unsigned THR_W    = DEF_THR_W,
   parameter int unsigned MODE_BIT = DEF_MODE_BIT,
   parameter int unsigned SHDN_BIT = DEF_SHDN_BIT,
   parameter bit          REG_CMP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              new_data_i,
   input  logic              rd_strobe_i,
   input  logic [DATA_W-1:0] result_i,
   input  logic [DATA_W-1:0] cfg_i,
   output logic              alert_oe_o
);
   localparam int unsigned THR_LSB = DATA_W - THR_W;
   localparam logic [DATA_W-1:0] USED_MASK =
      ({DATA_W{1'b1}} << THR_LSB) | (DATA_W'(1) << MODE_BIT) | (DATA_W'(1) << SHDN_BIT);

   if (MODE_BIT >= THR_LSB || SHDN_BIT >= THR_LSB || MODE_BIT == SHDN_BIT) begin : g_bad_layout
      $error("alert_ctrl: mode and shutdown bits must sit below the threshold field");
   end

   alert_mode_e       mode_now;
   alert_mode_e       mode_q;
   logic              shdn;
   logic              mode_flip;
   logic [THR_W-1:0]  thr;
   logic              ready_flag;
   logic              above;
   logic              unused_cfg;

   assign mode_now   = alert_mode_e'(cfg_i[MODE_BIT]);
   assign shdn       = cfg_i[SHDN_BIT];
   assign thr        = cfg_i[DATA_W-1:THR_LSB];
   assign mode_flip  = (mode_now != mode_q);
   assign unused_cfg = ^(cfg_i & ~USED_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= ALERT_READY;
      else
         mode_q <= mode_now;
   end

   alert_ready_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (new_data_i),
      .rel_i  (rd_strobe_i),
      .clr_i  (mode_flip | shdn),
      .flag_o (ready_flag)
   );

   alert_level_cmp #(
      .DATA_W  (DATA_W),
      .THR_W   (THR_W),
      .REG_CMP (REG_CMP)
   ) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .result_i (result_i),
      .thr_i    (thr),
      .above_o  (above)
   );

   always_comb begin
      if (shdn)
         alert_oe_o = 1'b0;
      else if (mode_now == ALERT_LEVEL)
         alert_oe_o = above;
      else
         alert_oe_o = ready_flag;
   end

   // R8: shutdown always leaves the pin released
   p_shdn_r8: assert property (@(posedge clk) disable iff (!rst_n)
      shdn |-> !alert_oe_o);
   // R7: returning to data-ready mode with no new data shows the pin released
   p_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_now == ALERT_READY && mode_q == ALERT_LEVEL && !new_data_i
      |=> (mode_now == ALERT_LEVEL) || new_data_i || !alert_oe_o);
   // R1: the pin is released in the first cycle after reset
   p_reset_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> !alert_oe_o || new_data_i || mode_now == ALERT_LEVEL);
endmodule

// File: tb/alert_ctrl_test.sv
module alert_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        new_data_i = 1'b0;
   logic        rd_strobe_i = 1'b0;
   logic [15:0] result_i = '0;
   logic [15:0] cfg_i = '0;
   logic        alert_oe_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit    exp_q[$];
   string tag_q[$];

   bit m_flag = 1'b0;
   bit m_mode = 1'b0;
   bit m_above = 1'b0;

   always #4 clk = ~clk;

   alert_ctrl uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .new_data_i  (new_data_i),
      .rd_strobe_i (rd_strobe_i),
      .result_i    (result_i),
      .cfg_i       (cfg_i),
      .alert_oe_o  (alert_oe_o)
   );

   function automatic logic [15:0] lvl_cfg(input logic [6:0] thr);
      return {thr, 1'b1, 8'h00};
   endfunction

   task automatic step(input bit nd, input bit rd, input logic [15:0] res,
                       input logic [15:0] cfg, input string tag);
      bit mode;
      bit sh;
      bit exp;
      @(negedge clk);
      new_data_i  = nd;
      rd_strobe_i = rd;
      result_i    = res;
      cfg_i       = cfg;
      mode = cfg[8];
      sh   = cfg[4];
      if (mode != m_mode || sh) m_flag = 1'b0;
      else if (nd)              m_flag = 1'b1;
      else if (rd)              m_flag = 1'b0;
      m_mode  = mode;
      m_above = $signed(res) > $signed({cfg[15:9], 9'b0});
      exp = sh ? 1'b0 : (mode ? m_above : m_flag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         bit    e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (alert_oe_o !== e) begin
            errors++;
            $display("FAIL %s: alert_oe_o=%b expected %b", t, alert_oe_o, e);
         end
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      checks++;
      if (alert_oe_o !== 1'b0) begin
         errors++;
         $display("FAIL R1: alert_oe_o=%b expected 0", alert_oe_o);
      end

      // R2 set and hold
      step(1, 0, 16'h0000, 16'h0000, "R2 set");
      step(0, 0, 16'h0000, 16'h0000, "R2 hold");
      step(0, 0, 16'h0000, 16'h0000, "R2 hold");
      // R3 release on read
      step(0, 1, 16'h0000, 16'h0000, "R3 release");
      step(0, 0, 16'h0000, 16'h0000, "R3 stay released");
      // R4 simultaneous pulses
      step(1, 0, 16'h0000, 16'h0000, "R4 set");
      step(1, 1, 16'h0000, 16'h0000, "R4 both");
      step(0, 1, 16'h0000, 16'h0000, "R4 later read");
      step(1, 1, 16'h0000, 16'h0000, "R4 both from clear");
      step(0, 1, 16'h0000, 16'h0000, "R3 read");

      // R5 threshold mode, positive threshold 512
      step(0, 0, 16'd600, lvl_cfg(7'd1), "R5 above");
      step(0, 0, 16'd512, lvl_cfg(7'd1), "R6 equal");
      step(0, 0, 16'd513, lvl_cfg(7'd1), "R5 just above");
      step(0, 0, 16'd100, lvl_cfg(7'd1), "R5 below");
      step(0, 0, 16'd1,   lvl_cfg(7'd0), "R5 zero thr above");
      step(0, 0, 16'd0,   lvl_cfg(7'd0), "R6 zero equal");
      step(0, 0, 16'hFFFF, lvl_cfg(7'd0), "R6 negative below zero");
      // R6 negative threshold -512
      step(0, 0, 16'hFE01, lvl_cfg(7'h7F), "R6 neg above");
      step(0, 0, 16'hFE00, lvl_cfg(7'h7F), "R6 neg equal");
      step(0, 0, 16'hFC18, lvl_cfg(7'h7F), "R6 neg below");
      step(0, 0, 16'h7FFF, lvl_cfg(7'h3F), "R5 max result");
      step(0, 0, 16'h8000, lvl_cfg(7'h40), "R6 min equal");

      // R9 pulses in threshold mode leave no trace
      step(1, 0, 16'd0, lvl_cfg(7'd2), "R9 pulse in level");
      step(0, 0, 16'd0, lvl_cfg(7'd2), "R9 level hold");
      step(0, 0, 16'd0, 16'h0000,      "R9 back to ready");
      step(0, 0, 16'd0, 16'h0000,      "R9 ready idle");

      // R7 mode change clears pending flag
      step(1, 0, 16'd0, 16'h0000,      "R7 set");
      step(0, 0, 16'd0, lvl_cfg(7'd0), "R7 flip to level");
      step(0, 0, 16'd0, 16'h0000,      "R7 back to ready");

      // R8 shutdown
      step(1, 0, 16'd0, 16'h0000, "R8 set");
      step(0, 0, 16'd0, 16'h0010, "R8 shutdown");
      step(0, 0, 16'd0, 16'h0000, "R8 resume cleared");
      step(0, 0, 16'd900, lvl_cfg(7'd0) | 16'h0010, "R8 shutdown level");
      step(0, 0, 16'd900, lvl_cfg(7'd0), "R5 resume level");

      @(negedge clk);
      new_data_i  = 1'b0;
      rd_strobe_i = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule